// File: doc/BRIEF.md
# Branch Trace Entry Packer

The packer converts processor execution events into self-describing 6-bit trace entries and stores them in a small circular trace buffer. Three valid/ready sources feed it. The status source delivers a 5-bit per-instruction code. The branch source delivers a taken indirect branch with its target address. The data source delivers one 4-bit data nibble. The top two bits of each entry identify its kind, so software can walk the buffer without any side information.

A taken branch always produces the taken-branch status entry. Depending on a 2-bit address display mode, it may then produce a length marker and the target address shifted right by one. The address is sent one nibble per entry, least significant nibble first. While that tail is pending the block is busy and refuses every source. A source that raises valid must hold valid and its payload until it sees ready in the same cycle. At most one entry is produced per clock. Entries go through one output register to the buffer write port, and the write pointer wraps around the buffer. A separate read address port returns stored entries for post-processing.

Top module: `brtrace_packer`

## Requirements
- R1: An accepted status code C produces, one cycle later, an entry with bit 5 = 0 and bits 4:0 = C.
- R2: An accepted data nibble D produces, one cycle later, an entry with bits 5:4 = 2'b11 and bits 3:0 = D.
- R3: An accepted branch produces, one cycle later, the status entry 6'h05; with mode 0 nothing further follows and busy stays low.
- R4: With mode 1, the cycles after the 6'h05 entry carry the marker 6'h0D, then four entries {2'b10, A[4:1]}, {2'b10, A[8:5]}, {2'b10, A[12:9]}, {2'b10, A[16:13]}, one per cycle.
- R5: With mode 2 or 3, the marker is 6'h0E, followed by six entries {2'b10, A[4n+4:4n+1]} for n = 0..5, one per cycle.
- R6: busy is high from the cycle the 6'h05 entry appears until the cycle the last address nibble appears, and wr_en is high in the cycle after every busy cycle.
- R7: br_ready is high exactly when not busy; st_ready is high when not busy and br_valid is low; dn_ready is high when not busy and both br_valid and st_valid are low. At most one source is accepted per cycle.
- R8: Each entry is written at wr_addr, and wr_addr then advances by one, wrapping from DEPTH-1 to 0; wr_addr holds when wr_en is low.
- R9: wrapped rises after the first write at address DEPTH-1 and stays high until reset.
- R10: rd_data returns the entry stored at rd_addr one clock after rd_addr is presented.
- R11: Reset clears wr_addr, wrapped, busy, wr_en and any address sequence in progress.
- R12: The display mode is sampled when the branch is accepted; a change in mode during the sequence does not alter its length or marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_mode | input | 2 | Address display: 0 none, 1 two bytes, 2 or 3 three bytes |
| br_valid | input | 1 | Taken indirect branch request |
| br_ready | output | 1 | Branch request accepted this cycle when valid |
| br_target | input | ADDR_W | Branch target address |
| st_valid | input | 1 | Status code request |
| st_ready | output | 1 | Status code accepted this cycle when valid |
| st_code | input | 5 | Status code |
| dn_valid | input | 1 | Data nibble request |
| dn_ready | output | 1 | Data nibble accepted this cycle when valid |
| dn_nibble | input | 4 | Data nibble |
| busy | output | 1 | Marker or address nibbles still pending |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | PTR_W | Buffer write pointer |
| wr_data | output | 6 | Entry being written |
| wrapped | output | 1 | Buffer has overflowed at least once |
| rd_addr | input | PTR_W | Readback address |
| rd_data | output | 6 | Entry at the previous rd_addr |

## Verification
The encoding assertions assume that a source's payload is stable during the cycle in which it is accepted. They also assume that no source expects acceptance while busy is high. They place no constraint on how long valid is held. The stimulus keeps any raised valid and its payload unchanged until the handshake completes, and only then draws a fresh request. This matches the back-pressure rule. The stimulus also changes the display mode while an address sequence is running, which checks that the mode is sampled once per branch.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

  typedef logic [5:0] entry_t;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_BRANCH,
    SRC_STATUS,
    SRC_DATA
  } src_e;

  // address bits [24:1] carried by the serializer
  localparam int TGT_BITS = 24;

  function automatic entry_t enc_status(input logic [4:0] code);
    return {1'b0, code};
  endfunction

  function automatic entry_t enc_addr(input logic [3:0] nib);
    return {2'b10, nib};
  endfunction

  function automatic entry_t enc_data(input logic [3:0] nib);
    return {2'b11, nib};
  endfunction

  // number of address nibbles for a display mode
  function automatic logic [2:0] nib_count(input logic [1:0] mode);
    case (mode)
      2'd0:    return 3'd0;
      2'd1:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/brtrace_arb.sv
module brtrace_arb
  import brtrace_pkg::*;
(
  input  logic busy,
  input  logic br_valid,
  input  logic st_valid,
  input  logic dn_valid,
  output logic br_ready,
  output logic st_ready,
  output logic dn_ready,
  output src_e grant
);

  // fixed priority: branch, status, data; nothing while a tail is pending
  assign br_ready = !busy;
  assign st_ready = !busy && !br_valid;
  assign dn_ready = !busy && !br_valid && !st_valid;

  always_comb begin
    if (busy)          grant = SRC_NONE;
    else if (br_valid) grant = SRC_BRANCH;
    else if (st_valid) grant = SRC_STATUS;
    else if (dn_valid) grant = SRC_DATA;
    else               grant = SRC_NONE;
  end

endmodule

// File: rtl/brtrace_addr_ser.sv
module brtrace_addr_ser
  import brtrace_pkg::*;
#(
  parameter logic [4:0] MARK_2B = 5'h0D,
  parameter logic [4:0] MARK_3B = 5'h0E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [1:0]          mode,
  input  logic [TGT_BITS-1:0] tgt,
  output logic                busy,
  output entry_t              ent
);

  logic [TGT_BITS-1:0] shreg;
  logic [2:0]          left;
  logic                mark_due;
  logic [4:0]          mark_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      left      <= '0;
      mark_due  <= 1'b0;
      mark_code <= '0;
    end else if (load) begin
      shreg     <= tgt;
      left      <= nib_count(mode);
      mark_due  <= (mode != 2'd0);
      mark_code <= (mode == 2'd1) ? MARK_2B : MARK_3B;
    end else if (mark_due) begin
      mark_due <= 1'b0;
    end else if (left != 3'd0) begin
      shreg <= shreg >> 4;
      left  <= left - 3'd1;
    end
  end

  assign busy = mark_due || (left != 3'd0);
  assign ent  = mark_due ? enc_status(mark_code) : enc_addr(shreg[3:0]);

endmodule

// File: rtl/brtrace_ring.sv
module brtrace_ring
  import brtrace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  entry_t           wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             wrapped,
  output entry_t           rd_data
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else if (wr_en) begin
      if (wr_ptr == LAST) begin
        wr_ptr  <= '0;
        wrapped <= 1'b1;
      end else begin
        wr_ptr <= wr_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/brtrace_packer.sv
module brtrace_packer
  import brtrace_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DEPTH     = 64,
  parameter logic [4:0]  BR_STATUS = 5'h05,
  parameter logic [4:0]  MARK_2B   = 5'h0D,
  parameter logic [4:0]  MARK_3B   = 5'h0E,
  localparam int         PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_addr_mode,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [4:0]        st_code,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic [3:0]        dn_nibble,
  output logic              busy,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [5:0]        wr_data,
  output logic              wrapped,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [5:0]        rd_data
);

  src_e   grant;
  logic   ser_busy;
  entry_t ser_ent;
  logic   nxt_v;
  entry_t nxt_d;
  logic   ent_v;
  entry_t ent_d;
  logic   tgt_unused;

  // bit 0 and bits above 24 never reach the trace
  assign tgt_unused = ^{br_target[0], br_target[ADDR_W-1:TGT_BITS+1]};

  brtrace_arb u_arb (
    .busy     (ser_busy),
    .br_valid (br_valid),
    .st_valid (st_valid),
    .dn_valid (dn_valid),
    .br_ready (br_ready),
    .st_ready (st_ready),
    .dn_ready (dn_ready),
    .grant    (grant)
  );

  brtrace_addr_ser #(
    .MARK_2B (MARK_2B),
    .MARK_3B (MARK_3B)
  ) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (grant == SRC_BRANCH),
    .mode  (cfg_addr_mode),
    .tgt   (br_target[TGT_BITS:1]),
    .busy  (ser_busy),
    .ent   (ser_ent)
  );

  always_comb begin
    nxt_v = 1'b1;
    nxt_d = '0;
    if (ser_busy) begin
      nxt_d = ser_ent;
    end else begin
      case (grant)
        SRC_BRANCH: nxt_d = enc_status(BR_STATUS);
        SRC_STATUS: nxt_d = enc_status(st_code);
        SRC_DATA:   nxt_d = enc_data(dn_nibble);
        default:    nxt_v = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= 1'b0;
      ent_d <= '0;
    end else begin
      ent_v <= nxt_v;
      ent_d <= nxt_d;
    end
  end

  brtrace_ring #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ent_v),
    .wr_data (ent_d),
    .rd_addr (rd_addr),
    .wr_ptr  (wr_addr),
    .wrapped (wrapped),
    .rd_data (rd_data)
  );

  assign busy    = ser_busy;
  assign wr_en   = ent_v;
  assign wr_data = ent_d;

endmodule

// File: rtl/brtrace_chk.sv
module brtrace_chk #(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_addr_mode,
  input logic             br_valid,
  input logic             br_ready,
  input logic             st_valid,
  input logic             st_ready,
  input logic [4:0]       st_code,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [3:0]       dn_nibble,
  input logic             busy,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_addr,
  input logic [5:0]       wr_data,
  input logic             wrapped
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic br_fire, st_fire, dn_fire;
  assign br_fire = br_valid && br_ready;
  assign st_fire = st_valid && st_ready;
  assign dn_fire = dn_valid && dn_ready;

  AST_STATUS_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |=> wr_en && wr_data == {1'b0, $past(st_code)});  // R1
  AST_DATA_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fire |=> wr_en && wr_data == {2'b11, $past(dn_nibble)});  // R2
  AST_BRANCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire |=> wr_en && wr_data == 6'h05);  // R3
  AST_NO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire && cfg_addr_mode == 2'd0 |=> !busy);  // R3
  AST_TAIL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    br_fire && cfg_addr_mode != 2'd0 |=> busy);  // R6
  AST_BUSY_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> wr_en);  // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !br_ready && !st_ready && !dn_ready);  // R7
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({br_fire, st_fire, dn_fire}) <= 1);  // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr == (($past(wr_addr) == LAST) ? '0 : $past(wr_addr) + 1'b1));  // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_addr));  // R8
  AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == LAST |=> wrapped);  // R9
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);  // R9

endmodule

bind brtrace_packer brtrace_chk #(
  .DEPTH (DEPTH),
  .PTR_W (PTR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_addr_mode (cfg_addr_mode),
  .br_valid      (br_valid),
  .br_ready      (br_ready),
  .st_valid      (st_valid),
  .st_ready      (st_ready),
  .st_code       (st_code),
  .dn_valid      (dn_valid),
  .dn_ready      (dn_ready),
  .dn_nibble     (dn_nibble),
  .busy          (busy),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .wrapped       (wrapped)
);

// File: tb/test_brtrace_packer.sv
`timescale 1ns/1ps
module test_brtrace_packer;

  localparam int AW    = 32;
  localparam int DEPTH = 64;
  localparam int PW    = 6;
  localparam int CYC   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_addr_mode = '0;
  logic          br_valid = 1'b0;
  logic          br_ready;
  logic [AW-1:0] br_target = '0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [4:0]    st_code = '0;
  logic          dn_valid = 1'b0;
  logic          dn_ready;
  logic [3:0]    dn_nibble = '0;
  logic          busy;
  logic          wr_en;
  logic [PW-1:0] wr_addr;
  logic [5:0]    wr_data;
  logic          wrapped;
  logic [PW-1:0] rd_addr = '0;
  logic [5:0]    rd_data;

  brtrace_packer #(.ADDR_W(AW), .DEPTH(DEPTH)) i_brtrace_packer (
    .clk(clk), .rst_n(rst_n), .cfg_addr_mode(cfg_addr_mode),
    .br_valid(br_valid), .br_ready(br_ready), .br_target(br_target),
    .st_valid(st_valid), .st_ready(st_ready), .st_code(st_code),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_nibble(dn_nibble),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrapped(wrapped), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CYC/2) clk = ~clk;

  // behavioural reference model
  int    q[$];
  string qtag[$];
  bit    m_v;
  int    m_d;
  string m_tag = "R8";
  int    m_ptr;
  bit    m_wrap;
  int    m_mem[DEPTH];
  bit    f_br, f_st, f_dn;
  int    n_chk = 0;
  int    n_err = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    q.delete(); qtag.delete();
    m_v = 0; m_d = 0; m_ptr = 0; m_wrap = 0;
  endtask

  task automatic tick();
    bit mb;
    int n;
    string t;
    #1;
    mb = (q.size() != 0);
    check("R7", "br_ready", br_ready, !mb);
    check("R7", "st_ready", st_ready, !mb && !br_valid);
    check("R7", "dn_ready", dn_ready, !mb && !br_valid && !st_valid);
    f_br = br_valid && !mb;
    f_st = st_valid && !mb && !br_valid;
    f_dn = dn_valid && !mb && !br_valid && !st_valid;
    if (m_v) begin
      m_mem[m_ptr] = m_d;
      if (m_ptr == DEPTH - 1) m_wrap = 1;
      m_ptr = (m_ptr + 1) % DEPTH;
    end
    if (mb) begin
      m_v = 1; m_d = q.pop_front(); m_tag = qtag.pop_front();
    end else if (f_br) begin
      m_v = 1; m_d = 6'h05; m_tag = "R3";
      n = (cfg_addr_mode == 0) ? 0 : (cfg_addr_mode == 1) ? 4 : 6;
      t = (n == 4) ? "R4" : "R5";
      if (n != 0) begin
        q.push_back((n == 4) ? 6'h0D : 6'h0E); qtag.push_back(t);
        for (int i = 0; i < n; i++) begin
          q.push_back(32 | int'((br_target >> (1 + 4 * i)) & 32'hF));
          qtag.push_back(t);
        end
      end
    end else if (f_st) begin
      m_v = 1; m_d = int'(st_code); m_tag = "R1";
    end else if (f_dn) begin
      m_v = 1; m_d = 48 | int'(dn_nibble); m_tag = "R2";
    end else begin
      m_v = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check("R8", "wr_en", wr_en, m_v);
    if (m_v) check(m_tag, "wr_data", wr_data, m_d);
    check("R8", "wr_addr", wr_addr, m_ptr);
    check("R9", "wrapped", wrapped, m_wrap);
    check("R6", "busy", busy, q.size() != 0);
  endtask

  task automatic idle(input int n);
    br_valid = 0; st_valid = 0; dn_valid = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic branch(input logic [1:0] mode, input logic [31:0] a);
    cfg_addr_mode = mode; br_target = a; br_valid = 1;
    tick();
    br_valid = 0;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired, run did not finish");
    report();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: state after reset
    check("R11", "wr_en", wr_en, 0);
    check("R11", "wr_addr", wr_addr, 0);
    check("R11", "wrapped", wrapped, 0);
    check("R11", "busy", busy, 0);

    // R1 status entries, R2 data entries
    st_code = 5'h1F; st_valid = 1; tick();
    st_code = 5'h00; tick();
    st_valid = 0;
    dn_nibble = 4'hA; dn_valid = 1; tick();
    dn_nibble = 4'h3; tick();
    idle(2);

    // R3 no address display
    branch(2'd0, 32'h0123_4567); idle(2);
    // R4 two-byte display
    branch(2'd1, 32'h00AB_CDE6); idle(7);
    // R5 three-byte display, modes 2 and 3
    branch(2'd2, 32'h01FE_DCBA); idle(9);
    branch(2'd3, 32'hFFFF_FFFF); idle(9);

    // R7 all three sources at once, then held while busy
    cfg_addr_mode = 2'd1; br_target = 32'h0000_1234;
    br_valid = 1; st_valid = 1; st_code = 5'h0B; dn_valid = 1; dn_nibble = 4'h7;
    tick();
    br_valid = 0;
    for (int i = 0; i < 6; i++) tick();
    st_valid = 0;
    for (int i = 0; i < 2; i++) tick();
    idle(1);

    // R12 mode change during the sequence does not alter it
    branch(2'd1, 32'h0055_AAAA);
    cfg_addr_mode = 2'd2;
    for (int i = 0; i < 5; i++) tick();
    check("R12", "busy after four nibbles", busy, 0);
    idle(2);

    // random traffic honouring the hold rule
    for (int k = 0; k < 600; k++) begin
      if (!(br_valid && !f_br)) begin
        br_valid  = ($urandom_range(0, 5) == 0);
        br_target = $urandom();
      end else if (!(st_valid && !f_st) && !(dn_valid && !f_dn)) begin
        cfg_addr_mode = 2'($urandom_range(0, 3));
      end
      if (f_br || !br_valid) cfg_addr_mode = 2'($urandom_range(0, 3));
      if (!(st_valid && !f_st)) begin
        st_valid = ($urandom_range(0, 2) == 0);
        st_code  = 5'($urandom());
      end
      if (!(dn_valid && !f_dn)) begin
        dn_valid  = ($urandom_range(0, 2) == 0);
        dn_nibble = 4'($urandom());
      end
      tick();
    end
    idle(12);
    check("R9", "wrapped after long run", wrapped, 1);

    // R10 readback of every location
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = PW'(i);
      @(posedge clk);
      @(negedge clk);
      check("R10", "rd_data", rd_data, m_mem[i]);
    end

    // R11 reset in the middle of an address sequence
    branch(2'd2, 32'h00FF_00FF);
    tick();
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    check("R11", "busy after reset", busy, 0);
    check("R11", "wr_en after reset", wr_en, 0);
    check("R11", "wr_addr after reset", wr_addr, 0);
    check("R11", "wrapped after reset", wrapped, 0);
    idle(3);
    st_code = 5'h09; st_valid = 1; tick();
    idle(2);

    report();
    $finish;
  end

endmodule